// File: doc/BRIEF.md
# Dual-Port Modulo Address Generator

This block is the pointer engine of a data-path address unit. It keeps six pointer registers, split into two groups of three. In every cycle it produces two data addresses at once, one from each group. After use, a pointer can be left as it is, stepped by a signed linear increment, or stepped inside a circular buffer whose length is set by a size register. An indexed mode instead adds a common base register to the pointer and leaves the pointer unchanged.

A stack pointer produces push and pop addresses. Four alternate registers can each be swapped with one of the low pointers in a single cycle, which lets an interrupt handler or a second task switch its buffer pointers without extra cycles. A minimum/maximum tracker records the lowest and highest data address issued since reset.

All configuration and pointer loads go through one indexed write port. The memory that the addresses feed is outside this block.

Top module: `agu_dual_addr`

## Requirements
- R1: After reset all pointers, alternates, the base and the stack pointer are 0, the size is 0 and the step is 1. `lo_mark` reads 16'hFFFF and `hi_mark` reads 16'h0000.
- R2: Port A uses pointer `a_sel` (0..2) and port B uses pointer 3+`b_sel`. Both addresses are combinational and valid in the same cycle. When a request is low, or its select is 3, the port drives 0 and changes no pointer.
- R3: Mode 1 (linear) drives the pointer value and then loads pointer+step, modulo 2^16, at the clock edge.
- R4: Mode 2 (modulo) drives the pointer value and then steps it inside an aligned window. Let k be the smallest value with 2^k >= size, and let off be the low k bits of the pointer. The new value is off+step. It is reduced by size when the step is non-negative and the sum is >= size, and raised by size when the step is negative and the sum is below 0. The upper bits of the pointer are kept.
- R5: Mode 3 (indexed) drives base+pointer, modulo 2^16, and leaves the pointer unchanged.
- R6: Mode 0 (hold) drives the pointer value and leaves it unchanged.
- R7: When `wr_en` is high, `wr_idx` selects the target: 0..5 a pointer, 6 size, 7 step, 8 base, 9 stack pointer, 10..13 alternate 0..3. Other codes are ignored. A write wins over every other update of the same register in that cycle, and the new value is used from the next cycle on.
- R8: `stk_addr` shows the stack pointer. On a push it shows sp-1, and sp is loaded with sp-1. On a pop without a push, sp is loaded with sp+1. When both are high, the push wins.
- R9: When `xchg_en` is high, pointer `xchg_sel` and alternate `xchg_sel` swap contents at the edge. The swap wins over a post-modify of that pointer.
- R10: From the cycle after an address is issued, `lo_mark` and `hi_mark` hold the minimum and maximum of all addresses issued by ports with a valid request and select.

Ports follow in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A request |
| a_sel | input | 2 | Port A pointer select (0..2) |
| a_mode | input | 2 | Port A modifier: 0 hold, 1 linear, 2 modulo, 3 indexed |
| a_addr | output | 16 | Port A address |
| b_req | input | 1 | Port B request |
| b_sel | input | 2 | Port B pointer select (pointer 3+sel) |
| b_mode | input | 2 | Port B modifier, same coding as port A |
| b_addr | output | 16 | Port B address |
| stk_push | input | 1 | Stack push |
| stk_pop | input | 1 | Stack pop |
| stk_addr | output | 16 | Stack address |
| xchg_en | input | 1 | Swap pointer with alternate |
| xchg_sel | input | 2 | Alternate / pointer index for the swap |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write target |
| wr_data | input | 16 | Register write data |
| lo_mark | output | 16 | Lowest address issued |
| hi_mark | output | 16 | Highest address issued |

## Verification
A directed opening sets up a five-entry circular buffer at a non-zero window. It steps the buffer forward past the top and backward past the bottom, which separates a correct wrap from plain linear addition and from masking alone. Linear, indexed and hold accesses on both ports in the same cycle show that the two groups are independent and that indexed access leaves the pointer alone. Swaps, pushes and pops are placed against simultaneous writes to show the priority order. A long random phase then mixes odd buffer sizes, large and negative steps, and out-of-range selects and write codes. A reference model, which applies the rules of each requirement, is compared against the design in every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      AM_HOLD = 2'd0,
      AM_LIN  = 2'd1,
      AM_MOD  = 2'd2,
      AM_IDX  = 2'd3
   } agu_mode_e;

   localparam int unsigned GRP      = 3;
   localparam int unsigned NPTR     = 2 * GRP;
   localparam int unsigned IDXW     = 4;
   localparam int unsigned IDX_SIZE = NPTR;
   localparam int unsigned IDX_STEP = NPTR + 1;
   localparam int unsigned IDX_BASE = NPTR + 2;
   localparam int unsigned IDX_SP   = NPTR + 3;
   localparam int unsigned IDX_ALT0 = NPTR + 4;
endpackage

// File: rtl/agu_modstep.sv
module agu_modstep #(
   parameter int unsigned AW = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] size,
   input  logic [1:0]    mode,
   output logic [AW-1:0] nxt,
   output logic [AW-1:0] mask_o
);
   import agu_pkg::*;

   localparam int unsigned SW = AW + 2;

   logic [AW-1:0]        mask;
   logic                 found;
   logic [AW:0]          pow;
   logic signed [SW-1:0] off_s, step_s, size_s, sum_s;
   logic [AW-1:0]        wrap;

   // smallest power of two covering the buffer length
   always_comb begin
      mask  = '0;
      found = 1'b0;
      pow   = '0;
      for (int k = 0; k <= int'(AW); k++) begin
         pow = (AW+1)'(1) << k;
         if (!found && (pow >= {1'b0, size})) begin
            found = 1'b1;
            mask  = AW'(pow - (AW+1)'(1));
         end
      end
   end

   always_comb begin
      off_s  = SW'({2'b00, cur & mask});
      step_s = SW'({{2{step[AW-1]}}, step});
      size_s = SW'({2'b00, size});
      sum_s  = off_s + step_s;
      if (!step[AW-1] && (sum_s >= size_s))
         sum_s = sum_s - size_s;
      else if (step[AW-1] && (sum_s < 0))
         sum_s = sum_s + size_s;
      wrap = (cur & ~mask) | (sum_s[AW-1:0] & mask);
   end

   always_comb begin
      unique case (agu_mode_e'(mode))
         AM_LIN:  nxt = cur + step;
         AM_MOD:  nxt = wrap;
         default: nxt = cur;
      endcase
   end

   assign mask_o = mask;
endmodule

// File: rtl/agu_extent.sv
module agu_extent #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          va,
   input  logic [AW-1:0] a,
   input  logic          vb,
   input  logic [AW-1:0] b,
   output logic [AW-1:0] lo,
   output logic [AW-1:0] hi
);
   logic          seen;
   logic [AW-1:0] lo_n, hi_n;

   always_comb begin
      lo_n = lo;
      hi_n = hi;
      if (va && a < lo_n) lo_n = a;
      if (vb && b < lo_n) lo_n = b;
      if (va && a > hi_n) hi_n = a;
      if (vb && b > hi_n) hi_n = b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo   <= '1;
         hi   <= '0;
         seen <= 1'b0;
      end else begin
         lo   <= lo_n;
         hi   <= hi_n;
         seen <= seen | va | vb;
      end
   end

   // R10
   extent_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (lo <= hi));
   // R10
   extent_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      va |=> (lo <= $past(a)));
   // R10
   extent_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vb |=> (hi >= $past(b)));
endmodule

// File: rtl/agu_dual_addr.sv
module agu_dual_addr #(
   parameter int unsigned AW   = 16,
   parameter int unsigned NALT = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        a_req,
   input  logic [1:0]  a_sel,
   input  logic [1:0]  a_mode,
   output logic [15:0] a_addr,
   input  logic        b_req,
   input  logic [1:0]  b_sel,
   input  logic [1:0]  b_mode,
   output logic [15:0] b_addr,
   input  logic        stk_push,
   input  logic        stk_pop,
   output logic [15:0] stk_addr,
   input  logic        xchg_en,
   input  logic [1:0]  xchg_sel,
   input  logic        wr_en,
   input  logic [3:0]  wr_idx,
   input  logic [15:0] wr_data,
   output logic [15:0] lo_mark,
   output logic [15:0] hi_mark
);
   import agu_pkg::*;

   localparam int unsigned XW = $clog2(NALT);

   if (AW != 16) begin : g_aw_bad
      $error("agu_dual_addr: port widths are fixed at 16 bits");
   end
   if (NALT > GRP + 1 || NALT < 1) begin : g_alt_bad
      $error("agu_dual_addr: NALT out of range");
   end
   if (XW != 2) begin : g_xw_bad
      $error("agu_dual_addr: swap select is two bits wide");
   end

   logic [AW-1:0] ptr_q [NPTR];
   logic [AW-1:0] alt_q [NALT];
   logic [AW-1:0] size_q, step_q, base_q, sp_q;

   logic          p_req  [2];
   logic [1:0]    p_sel  [2];
   logic [1:0]    p_mode [2];
   logic          p_hit  [2];
   logic          p_upd  [2];
   logic [AW-1:0] p_cur  [2];
   logic [AW-1:0] p_nxt  [2];
   logic [AW-1:0] p_mask [2];
   logic [AW-1:0] p_addr [2];

   assign p_req[0]  = a_req;
   assign p_sel[0]  = a_sel;
   assign p_mode[0] = a_mode;
   assign p_req[1]  = b_req;
   assign p_sel[1]  = b_sel;
   assign p_mode[1] = b_mode;
   assign a_addr    = p_addr[0];
   assign b_addr    = p_addr[1];

   for (genvar p = 0; p < 2; p++) begin : g_port
      always_comb begin
         p_cur[p] = '0;
         for (int s = 0; s < int'(GRP); s++)
            if (p_sel[p] == 2'(s)) p_cur[p] = ptr_q[p*GRP + s];
      end

      assign p_hit[p] = p_req[p] && (p_sel[p] < 2'(GRP));
      assign p_upd[p] = p_hit[p] &&
                        (agu_mode_e'(p_mode[p]) == AM_LIN || agu_mode_e'(p_mode[p]) == AM_MOD);

      agu_modstep #(.AW(AW)) i_step (
         .cur    (p_cur[p]),
         .step   (step_q),
         .size   (size_q),
         .mode   (p_mode[p]),
         .nxt    (p_nxt[p]),
         .mask_o (p_mask[p])
      );

      assign p_addr[p] = !p_hit[p] ? '0 :
                         (agu_mode_e'(p_mode[p]) == AM_IDX) ? (base_q + p_cur[p]) : p_cur[p];

      // R4
      mod_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (p_hit[p] && agu_mode_e'(p_mode[p]) == AM_MOD && size_q != '0 &&
          ((p_cur[p] & p_mask[p]) < size_q) &&
          (step_q[AW-1] ? ((~step_q + 1'b1) <= size_q) : (step_q <= size_q)))
         |-> ((p_nxt[p] & p_mask[p]) < size_q));
   end

   for (genvar i = 0; i < int'(NPTR); i++) begin : g_ptr
      localparam int unsigned OWN = i / GRP;
      localparam int unsigned LOC = i % GRP;
      logic wr_hit, sw_hit;
      assign wr_hit = wr_en && (wr_idx == IDXW'(i));
      if (i < int'(NALT)) begin : g_sw
         assign sw_hit = xchg_en && (xchg_sel == XW'(i));
      end else begin : g_nosw
         assign sw_hit = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr_q[i] <= '0;
         else if (wr_hit)
            ptr_q[i] <= wr_data;
         else if (sw_hit)
            ptr_q[i] <= alt_q[i % NALT];
         else if (p_upd[OWN] && p_sel[OWN] == 2'(LOC))
            ptr_q[i] <= p_nxt[OWN];
      end
   end

   for (genvar j = 0; j < int'(NALT); j++) begin : g_alt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alt_q[j] <= '0;
         else if (wr_en && wr_idx == IDXW'(IDX_ALT0 + j))
            alt_q[j] <= wr_data;
         else if (xchg_en && xchg_sel == XW'(j))
            alt_q[j] <= ptr_q[j];
      end

      // R9
      xchg_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (xchg_en && xchg_sel == XW'(j) &&
          !(wr_en && (wr_idx == IDXW'(j) || wr_idx == IDXW'(IDX_ALT0 + j))))
         |=> (alt_q[j] == $past(ptr_q[j]) && ptr_q[j] == $past(alt_q[j])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         step_q <= AW'(1);
         base_q <= '0;
      end else if (wr_en) begin
         if (wr_idx == IDXW'(IDX_SIZE)) size_q <= wr_data;
         if (wr_idx == IDXW'(IDX_STEP)) step_q <= wr_data;
         if (wr_idx == IDXW'(IDX_BASE)) base_q <= wr_data;
      end
   end

   logic sp_wr;
   assign sp_wr = wr_en && (wr_idx == IDXW'(IDX_SP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= '0;
      else if (sp_wr)
         sp_q <= wr_data;
      else if (stk_push)
         sp_q <= sp_q - AW'(1);
      else if (stk_pop)
         sp_q <= sp_q + AW'(1);
   end

   assign stk_addr = stk_push ? (sp_q - AW'(1)) : sp_q;

   // R8
   push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push && !sp_wr) |=> (sp_q == $past(sp_q) - AW'(1)));
   // R8
   pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_pop && !stk_push && !sp_wr) |=> (sp_q == $past(sp_q) + AW'(1)));

   agu_extent #(.AW(AW)) i_extent (
      .clk   (clk),
      .rst_n (rst_n),
      .va    (p_hit[0]),
      .a     (p_addr[0]),
      .vb    (p_hit[1]),
      .b     (p_addr[1]),
      .lo    (lo_mark),
      .hi    (hi_mark)
   );
endmodule

// File: tb/test_agu_dual_addr.sv
`timescale 1ns/1ps
module test_agu_dual_addr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_req = 0, b_req = 0, stk_push = 0, stk_pop = 0, xchg_en = 0, wr_en = 0;
   logic [1:0]  a_sel = 0, a_mode = 0, b_sel = 0, b_mode = 0, xchg_sel = 0;
   logic [3:0]  wr_idx = 0;
   logic [15:0] wr_data = 0;
   logic [15:0] a_addr, b_addr, stk_addr, lo_mark, hi_mark;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   int m_ptr [6];
   int m_alt [4];
   int m_size, m_step, m_base, m_sp, m_lo, m_hi;

   always #2 clk = ~clk;

   agu_dual_addr i_agu_dual_addr (
      .clk(clk), .rst_n(rst_n),
      .a_req(a_req), .a_sel(a_sel), .a_mode(a_mode), .a_addr(a_addr),
      .b_req(b_req), .b_sel(b_sel), .b_mode(b_mode), .b_addr(b_addr),
      .stk_push(stk_push), .stk_pop(stk_pop), .stk_addr(stk_addr),
      .xchg_en(xchg_en), .xchg_sel(xchg_sel),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .lo_mark(lo_mark), .hi_mark(hi_mark));

   function automatic int step_of(int cur, int md);
      int k, mask, off, s, sum;
      if (md == 1) return (cur + m_step) & 'hFFFF;
      if (md != 2) return cur;
      k = 0;
      while ((1 << k) < m_size) k++;
      mask = (1 << k) - 1;
      off  = cur & mask;
      s    = (m_step >= 32768) ? m_step - 65536 : m_step;
      sum  = off + s;
      if (s >= 0 && sum >= m_size) sum -= m_size;
      else if (s < 0 && sum < 0) sum += m_size;
      return (cur & ~mask & 'hFFFF) | (sum & mask);
   endfunction

   function automatic int addr_of(bit rq, int grp, int sel, int md);
      if (!rq || sel > 2) return 0;
      if (md == 3) return (m_base + m_ptr[grp*3 + sel]) & 'hFFFF;
      return m_ptr[grp*3 + sel];
   endfunction

   task automatic cmp(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      foreach (m_ptr[i]) m_ptr[i] = 0;
      foreach (m_alt[i]) m_alt[i] = 0;
      m_size = 0; m_step = 1; m_base = 0; m_sp = 0; m_lo = 'hFFFF; m_hi = 0;
   endtask

   task automatic model_clock();
      int ea, eb, na, nb, ia, ib;
      bit ha, hb;
      int nptr [6];
      int nalt [4];
      ha = a_req && a_sel < 3;
      hb = b_req && b_sel < 3;
      ea = addr_of(a_req, 0, a_sel, a_mode);
      eb = addr_of(b_req, 1, b_sel, b_mode);
      foreach (nptr[i]) nptr[i] = m_ptr[i];
      foreach (nalt[i]) nalt[i] = m_alt[i];
      if (ha && (a_mode == 1 || a_mode == 2)) nptr[a_sel] = step_of(m_ptr[a_sel], a_mode);
      if (hb && (b_mode == 1 || b_mode == 2)) nptr[3+b_sel] = step_of(m_ptr[3+b_sel], b_mode);
      if (xchg_en) begin
         nptr[xchg_sel] = m_alt[xchg_sel];
         nalt[xchg_sel] = m_ptr[xchg_sel];
      end
      if (stk_push) m_sp = (m_sp - 1) & 'hFFFF;
      else if (stk_pop) m_sp = (m_sp + 1) & 'hFFFF;
      if (wr_en) begin
         if (wr_idx < 6) nptr[wr_idx] = wr_data;
         else if (wr_idx == 6) m_size = wr_data;
         else if (wr_idx == 7) m_step = wr_data;
         else if (wr_idx == 8) m_base = wr_data;
         else if (wr_idx == 9) m_sp = wr_data;
         else if (wr_idx < 14) nalt[wr_idx-10] = wr_data;
      end
      if (ha && ea < m_lo) m_lo = ea;
      if (hb && eb < m_lo) m_lo = eb;
      if (ha && ea > m_hi) m_hi = ea;
      if (hb && eb > m_hi) m_hi = eb;
      foreach (nptr[i]) m_ptr[i] = nptr[i];
      foreach (nalt[i]) m_alt[i] = nalt[i];
   endtask

   // drive at negedge, compare, clock, update model
   task automatic cyc(string tag,
                      bit ar, int as, int am, bit br, int bs, int bm,
                      bit pu, bit po, bit xe, int xs, bit we, int wi, int wd);
      a_req = ar; a_sel = 2'(as); a_mode = 2'(am);
      b_req = br; b_sel = 2'(bs); b_mode = 2'(bm);
      stk_push = pu; stk_pop = po; xchg_en = xe; xchg_sel = 2'(xs);
      wr_en = we; wr_idx = 4'(wi); wr_data = 16'(wd);
      #1;
      cmp(tag, "a_addr (R2)", a_addr, addr_of(ar, 0, as, am));
      cmp(tag, "b_addr (R2)", b_addr, addr_of(br, 1, bs, bm));
      cmp(tag, "stk_addr (R8)", stk_addr, pu ? ((m_sp - 1) & 'hFFFF) : m_sp);
      cmp(tag, "lo_mark (R10)", lo_mark, m_lo);
      cmp(tag, "hi_mark (R10)", hi_mark, m_hi);
      @(posedge clk);
      model_clock();
      @(negedge clk);
   endtask

   task automatic idle(string tag);
      cyc(tag, 0,0,0, 0,0,0, 0,0, 0,0, 0,0,0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state at the ports
      idle("R1");
      // R7: loads through the write port
      cyc("R7", 0,0,0, 0,0,0, 0,0, 0,0, 1, 0, 'h0044);
      cyc("R7", 0,0,0, 0,0,0, 0,0, 0,0, 1, 3, 'h1000);
      cyc("R7", 0,0,0, 0,0,0, 0,0, 0,0, 1, 6, 5);
      cyc("R7", 0,0,0, 0,0,0, 0,0, 0,0, 1, 8, 'h2000);
      cyc("R7", 0,0,0, 0,0,0, 0,0, 0,0, 1, 9, 'h0100);
      cyc("R7", 0,0,0, 0,0,0, 0,0, 0,0, 1, 15, 'hBEEF);
      // R2 and R6: both ports in one cycle, hold mode
      cyc("R6", 1,0,0, 1,0,0, 0,0, 0,0, 0,0,0);
      cyc("R2", 1,3,1, 1,3,1, 0,0, 0,0, 0,0,0);
      // R4: forward wrap 0x44 -> 0x40, then backwards
      cyc("R4", 1,0,2, 0,0,0, 0,0, 0,0, 0,0,0);
      cyc("R4", 1,0,0, 0,0,0, 0,0, 0,0, 1, 7, 'hFFFF);
      cyc("R4", 1,0,2, 0,0,0, 0,0, 0,0, 0,0,0);
      cyc("R4", 1,0,2, 0,0,0, 0,0, 0,0, 1, 7, 2);
      repeat (4) cyc("R4", 1,0,2, 0,0,0, 0,0, 0,0, 0,0,0);
      // R3: linear on port B
      repeat (3) cyc("R3", 0,0,0, 1,0,1, 0,0, 0,0, 0,0,0);
      // R5: indexed leaves the pointer unchanged
      repeat (2) cyc("R5", 1,0,3, 1,0,3, 0,0, 0,0, 0,0,0);
      cyc("R5", 1,0,0, 1,0,0, 0,0, 0,0, 0,0,0);
      // R7: write beats post-modify
      cyc("R7", 1,0,1, 0,0,0, 0,0, 0,0, 1, 0, 'h0300);
      cyc("R7", 1,0,0, 0,0,0, 0,0, 0,0, 0,0,0);
      // R9: swap, and swap beating post-modify
      cyc("R9", 0,0,0, 0,0,0, 0,0, 0,0, 1, 10, 'h0555);
      cyc("R9", 1,0,1, 0,0,0, 0,0, 1,0, 0,0,0);
      cyc("R9", 1,0,0, 0,0,0, 0,0, 1,0, 0,0,0);
      cyc("R9", 1,0,0, 0,0,0, 0,0, 0,0, 0,0,0);
      cyc("R9", 0,0,0, 1,0,0, 0,0, 1,3, 0,0,0);
      cyc("R9", 0,0,0, 1,0,0, 0,0, 0,0, 0,0,0);
      // R8: push, pop, both, write priority
      cyc("R8", 0,0,0, 0,0,0, 1,0, 0,0, 0,0,0);
      cyc("R8", 0,0,0, 0,0,0, 1,0, 0,0, 0,0,0);
      cyc("R8", 0,0,0, 0,0,0, 0,1, 0,0, 0,0,0);
      cyc("R8", 0,0,0, 0,0,0, 1,1, 0,0, 0,0,0);
      cyc("R8", 0,0,0, 0,0,0, 1,0, 0,0, 1, 9, 'h7000);
      idle("R8");
      // random mix, model compared every cycle
      for (int n = 0; n < 6000; n++) begin
         int wi, wd;
         wi = $urandom % 16;
         wd = $urandom % 65536;
         if (wi == 6 && ($urandom % 4) != 0) wd = 1 + $urandom % 40;
         if (wi == 7 && ($urandom % 4) != 0) wd = ($urandom % 17 + 65536 - 8) & 'hFFFF;
         cyc("R2", ($urandom % 5) != 0, $urandom % 4, $urandom % 4,
                   ($urandom % 5) != 0, $urandom % 4, $urandom % 4,
                   ($urandom % 5) == 0, ($urandom % 5) == 0,
                   ($urandom % 7) == 0, $urandom % 4,
                   ($urandom % 3) == 0, wi, wd);
      end
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule